// File: doc/BRIEF.md
# Page Access Rights Fault Checker

This block turns the protection fields of an already matched translation entry into a permitted-rights mask. It also produces at most one fault code for the access being attempted. Each request carries the following:

- the privilege level of the requester (two bits, where a smaller number means more privileged);
- the access kind (none, read, write or execute);
- a physical-mode flag;
- a hit flag from the lookup stage that sits in front of this block;
- a flag marking a translate-address query;
- the virtual address;
- the entry's page number, access type, two privilege bounds (a read bound and a write bound) and three page flags (dirty, break and reference-trap).

The evaluation itself is combinational. The answer is registered and returned one cycle after the request strobe. With it come the physical address, a 3-bit rights vector, a 4-bit fault code and a fault-valid flag.

Two states drive the output side. IDLE means no result is presented. RESP means the output registers hold the answer to the request strobed on the previous edge. The transitions are:

- ACCEPT: IDLE to RESP when req_valid is high.
- STREAM: RESP to RESP when req_valid is high.
- DRAIN: RESP to IDLE when req_valid is low.
- WAIT: IDLE to IDLE when req_valid is low.

Top module: `pgchk_top`

## Requirements
- R1: With the privilege level `p` and the entry bounds `rb` (ent_pl1) and `wb` (ent_pl2), the raw rights are as follows. Read is allowed when p <= rb. Write is allowed when p <= wb. Execute is allowed when wb <= p <= rb. The rights vector is {exec, write, read}, meaning bit 2 is exec, bit 1 is write and bit 0 is read.
- R2: The entry type selects rights from the raw rights:
  - type 0: read only;
  - type 1: read and write;
  - type 2: read and execute;
  - type 3: read, write and execute;
  - types 4 to 7: execute only.
- R3: When req_phys is high, the result grants rights 3'b111 and no fault, and the physical address equals the virtual address. The hit flag and all entry fields are ignored in this case.
- R4: Access kind 0 (none, a probe) returns the type-selected rights mask without any page-flag masking and never raises a fault.
- R5: The request is encoded as read = kind 1, write = kind 2 and execute = kind 3. If the selected rights lack the requested right, the fault is chosen this way:
  - insn-protection (4) for an execute request;
  - otherwise data-protection (5) if read is granted;
  - otherwise data-access-rights (6).
  In all three cases the rights mask is returned unmasked.
- R6: For a permitted read, write or execute, three checks are applied in this order, and a later fault code replaces an earlier one:
  - dirty clear: a write raises dirty (7), and write is removed from the mask;
  - break set: a write raises break (8), and write is removed from the mask;
  - reference-trap set: any non-execute access raises page-reference (9), and only exec is kept in the mask.
- R7: When req_phys is low and req_hit is low, the rights are 0 and the physical address is 0. An execute request yields insn-miss (1). Any other kind yields data-miss (2), except that a translate-address query turns data-miss into non-access data-miss (3).
- R8: On a hit outside physical mode, the physical address is the entry page number concatenated with the low OFS_W bits of the virtual address.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and the response carries that request's result. While in reset, rsp_valid, rsp_rights, rsp_fault and rsp_fault_valid are 0.
- R10: Code 0 means no fault. rsp_fault_valid is high exactly when rsp_fault is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; all request inputs are sampled with it |
| req_phys | input | 1 | Physical mode: bypass translation |
| req_hit | input | 1 | A matching valid entry was found |
| req_xlate_query | input | 1 | Translate-address query (miss code substitution) |
| req_kind | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| req_priv | input | 2 | Current privilege level |
| req_vaddr | input | ADDR_W | Virtual address |
| ent_ppn | input | ADDR_W-OFS_W | Entry physical page number |
| ent_type | input | 3 | Entry access type |
| ent_pl1 | input | 2 | Read privilege bound (upper bound of the execute band) |
| ent_pl2 | input | 2 | Write privilege bound (lower bound of the execute band) |
| ent_dirty | input | 1 | Page dirty flag |
| ent_break | input | 1 | Data break flag |
| ent_trap | input | 1 | Reference-trap flag |
| rsp_valid | output | 1 | Response valid |
| rsp_rights | output | 3 | Granted rights {exec, write, read} |
| rsp_fault_valid | output | 1 | A fault is reported |
| rsp_fault | output | 4 | Fault code |
| rsp_paddr | output | ADDR_W | Physical address |

## Verification
The main sweep is exhaustive over every entry type, both privilege bounds, every privilege level, every combination of the three page flags and all four access kinds. It covers 16384 hit patterns, streamed back to back. Privilege patterns where the bounds are crossed (the write bound above the read bound) separate the execute band from the plain read and write comparisons. Patterns that are denied but have page flags set show that protection faults win over the flag chain. Patterns with dirty clear and break set on a write, or with a flag under a reference trap, show the override order. Separate passes cover physical mode with random entry fields and misses (including misses on all kinds, with and without the query flag), and an idle gap shows that the response strobe drops.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE        = 4'd0,
        FLT_IMISS       = 4'd1,
        FLT_DMISS       = 4'd2,
        FLT_DMISS_NA    = 4'd3,
        FLT_INSN_PROT   = 4'd4,
        FLT_DATA_PROT   = 4'd5,
        FLT_DATA_RIGHTS = 4'd6,
        FLT_DIRTY       = 4'd7,
        FLT_BREAK       = 4'd8,
        FLT_PAGE_REF    = 4'd9
    } flt_e;

    localparam int RIGHTS_W = 3;
    localparam int RB_READ  = 0;
    localparam int RB_WRITE = 1;
    localparam int RB_EXEC  = 2;

    localparam logic [RIGHTS_W-1:0] RIGHTS_ALL  = 3'b111;
    localparam logic [RIGHTS_W-1:0] RIGHTS_NOWR = 3'b101;
    localparam logic [RIGHTS_W-1:0] RIGHTS_XO   = 3'b100;

endpackage

// File: rtl/pgchk_rights.sv
module pgchk_rights
    import pgchk_pkg::*;
#(
    parameter int PRIV_W = 2,
    parameter int TYPE_W = 3
) (
    input  logic [PRIV_W-1:0]   priv,
    input  logic [PRIV_W-1:0]   rd_bound,
    input  logic [PRIV_W-1:0]   wr_bound,
    input  logic [TYPE_W-1:0]   ar_type,
    output logic [RIGHTS_W-1:0] rights
);

    logic may_rd;
    logic may_wr;
    logic may_ex;

    always_comb begin
        may_rd = (priv <= rd_bound);
        may_wr = (priv <= wr_bound);
        may_ex = (wr_bound <= priv) && (priv <= rd_bound);
    end

    always_comb begin
        rights = '0;
        if (ar_type[TYPE_W-1:2] != '0) begin
            rights[RB_EXEC] = may_ex;
        end else begin
            unique case (ar_type[1:0])
                2'd0: rights[RB_READ] = may_rd;
                2'd1: begin
                    rights[RB_READ]  = may_rd;
                    rights[RB_WRITE] = may_wr;
                end
                2'd2: begin
                    rights[RB_READ] = may_rd;
                    rights[RB_EXEC] = may_ex;
                end
                2'd3: begin
                    rights[RB_READ]  = may_rd;
                    rights[RB_WRITE] = may_wr;
                    rights[RB_EXEC]  = may_ex;
                end
                default: rights = '0;
            endcase
        end
    end

endmodule

// File: rtl/pgchk_fault.sv
module pgchk_fault
    import pgchk_pkg::*;
(
    input  acc_e                kind,
    input  logic [RIGHTS_W-1:0] rights_in,
    input  logic                dirty,
    input  logic                brk,
    input  logic                trap_ref,
    output logic [RIGHTS_W-1:0] rights_out,
    output flt_e                code,
    output logic                flag
);

    logic [RIGHTS_W-1:0] want;
    logic                granted;

    always_comb begin
        want = '0;
        unique case (kind)
            ACC_NONE:  want = '0;
            ACC_READ:  want[RB_READ]  = 1'b1;
            ACC_WRITE: want[RB_WRITE] = 1'b1;
            ACC_EXEC:  want[RB_EXEC]  = 1'b1;
            default:   want = '0;
        endcase
        granted = |(want & rights_in);
    end

    always_comb begin
        rights_out = rights_in;
        code       = FLT_NONE;
        if (kind == ACC_NONE) begin
            code = FLT_NONE;
        end else if (!granted) begin
            if (kind == ACC_EXEC)           code = FLT_INSN_PROT;
            else if (rights_in[RB_READ])    code = FLT_DATA_PROT;
            else                            code = FLT_DATA_RIGHTS;
        end else begin
            // lowest priority first; later stages overwrite
            if (!dirty) begin
                if (kind == ACC_WRITE) code = FLT_DIRTY;
                rights_out = rights_out & RIGHTS_NOWR;
            end
            if (brk) begin
                if (kind == ACC_WRITE) code = FLT_BREAK;
                rights_out = rights_out & RIGHTS_NOWR;
            end
            if (trap_ref) begin
                if (kind != ACC_EXEC) code = FLT_PAGE_REF;
                rights_out = rights_out & RIGHTS_XO;
            end
        end
        flag = (kind != ACC_NONE) && (!granted || (code != FLT_NONE));
    end

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_phys,
    input  logic                 req_hit,
    input  logic                 req_xlate_query,
    input  logic [1:0]           req_kind,
    input  logic [1:0]           req_priv,
    input  logic [ADDR_W-1:0]    req_vaddr,
    input  logic [ADDR_W-OFS_W-1:0] ent_ppn,
    input  logic [2:0]           ent_type,
    input  logic [1:0]           ent_pl1,
    input  logic [1:0]           ent_pl2,
    input  logic                 ent_dirty,
    input  logic                 ent_break,
    input  logic                 ent_trap,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_rights,
    output logic                 rsp_fault_valid,
    output logic [3:0]           rsp_fault,
    output logic [ADDR_W-1:0]    rsp_paddr
);

    localparam int PPN_W = ADDR_W - OFS_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    state_e state_q;
    state_e state_d;

    logic [RIGHTS_W-1:0] raw_rights;
    logic [RIGHTS_W-1:0] chk_rights;
    flt_e                chk_code;
    logic                chk_flag;
    acc_e                kind;

    logic [RIGHTS_W-1:0] nxt_rights;
    flt_e                nxt_code;
    logic                nxt_flag;
    logic [ADDR_W-1:0]   nxt_paddr;

    logic [RIGHTS_W-1:0] rights_q;
    flt_e                code_q;
    logic                flag_q;
    logic [ADDR_W-1:0]   paddr_q;

    assign kind = acc_e'(req_kind);

    pgchk_rights #(.PRIV_W(2), .TYPE_W(3)) u_rights (
        .priv     (req_priv),
        .rd_bound (ent_pl1),
        .wr_bound (ent_pl2),
        .ar_type  (ent_type),
        .rights   (raw_rights)
    );

    pgchk_fault u_fault (
        .kind       (kind),
        .rights_in  (raw_rights),
        .dirty      (ent_dirty),
        .brk        (ent_break),
        .trap_ref   (ent_trap),
        .rights_out (chk_rights),
        .code       (chk_code),
        .flag       (chk_flag)
    );

    // result select: bypass, miss, or checked entry
    always_comb begin
        if (req_phys) begin
            nxt_rights = RIGHTS_ALL;
            nxt_code   = FLT_NONE;
            nxt_flag   = 1'b0;
            nxt_paddr  = req_vaddr;
        end else if (!req_hit) begin
            nxt_rights = '0;
            nxt_flag   = 1'b1;
            nxt_paddr  = '0;
            if (kind == ACC_EXEC)     nxt_code = FLT_IMISS;
            else if (req_xlate_query) nxt_code = FLT_DMISS_NA;
            else                      nxt_code = FLT_DMISS;
        end else begin
            nxt_rights = chk_rights;
            nxt_code   = chk_code;
            nxt_flag   = chk_flag;
            nxt_paddr  = {ent_ppn[PPN_W-1:0], req_vaddr[OFS_W-1:0]};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT, WAIT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rights_q <= '0;
            code_q   <= FLT_NONE;
            flag_q   <= 1'b0;
            paddr_q  <= '0;
        end else if (req_valid) begin
            rights_q <= nxt_rights;
            code_q   <= nxt_code;
            flag_q   <= nxt_flag;
            paddr_q  <= nxt_paddr;
        end
    end

    // outputs
    always_comb begin
        rsp_valid       = (state_q == ST_RESP);
        rsp_rights      = rights_q;
        rsp_fault       = code_q;
        rsp_fault_valid = flag_q;
        rsp_paddr       = paddr_q;
    end

endmodule

// File: rtl/pgchk_checker.sv
module pgchk_checker #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_phys,
    input logic              req_hit,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_rights,
    input logic              rsp_fault_valid,
    input logic [3:0]        rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9

    AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_valid == (rsp_fault != 4'd0)); // R10

    AST_PHYS_GRANT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_phys)) |->
            (rsp_rights == 3'b111 && !rsp_fault_valid && rsp_paddr == $past(req_vaddr))); // R3

    AST_PROBE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind == 2'd0 && req_hit && !req_phys)) |->
            !rsp_fault_valid); // R4

    AST_MISS_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!req_phys && !req_hit)) |->
            (rsp_rights == 3'b000 && rsp_fault_valid)); // R7

    AST_REF_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 4'd9) |-> (rsp_rights[1:0] == 2'b00)); // R6

endmodule

bind pgchk_top pgchk_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/pgchk_top_bench.sv
module pgchk_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int OFS_W  = 12;
    localparam int PPN_W  = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_phys = 1'b0;
    logic              req_hit = 1'b0;
    logic              req_xlate_query = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_priv = '0;
    logic [ADDR_W-1:0] req_vaddr = '0;
    logic [PPN_W-1:0]  ent_ppn = '0;
    logic [2:0]        ent_type = '0;
    logic [1:0]        ent_pl1 = '0;
    logic [1:0]        ent_pl2 = '0;
    logic              ent_dirty = 1'b0;
    logic              ent_break = 1'b0;
    logic              ent_trap = 1'b0;
    logic              rsp_valid;
    logic [2:0]        rsp_rights;
    logic              rsp_fault_valid;
    logic [3:0]        rsp_fault;
    logic [ADDR_W-1:0] rsp_paddr;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic              pend = 1'b0;
    logic [2:0]        e_rights;
    logic [3:0]        e_code;
    logic [ADDR_W-1:0] e_paddr;
    string             e_tag_main;
    logic              e_probe;
    logic [2:0]        e_type;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgchk_top #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_pgchk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phys(req_phys),
        .req_hit(req_hit), .req_xlate_query(req_xlate_query), .req_kind(req_kind),
        .req_priv(req_priv), .req_vaddr(req_vaddr), .ent_ppn(ent_ppn),
        .ent_type(ent_type), .ent_pl1(ent_pl1), .ent_pl2(ent_pl2),
        .ent_dirty(ent_dirty), .ent_break(ent_break), .ent_trap(ent_trap),
        .rsp_valid(rsp_valid), .rsp_rights(rsp_rights),
        .rsp_fault_valid(rsp_fault_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // independent model built from the requirements
    task automatic model(input logic phys, input logic hit, input logic xq,
                         input int kind, input int priv, input int typ,
                         input int rb, input int wb, input logic d,
                         input logic b, input logic t,
                         input logic [ADDR_W-1:0] va, input logic [PPN_W-1:0] ppn);
        int rd, wr, ex, r, want_bit;
        e_type  = typ[2:0];
        e_probe = (kind == 0);
        if (phys) begin
            e_rights = 3'b111; e_code = 4'd0; e_paddr = va; e_tag_main = "R3";
            return;
        end
        if (!hit) begin
            e_rights = 3'b000; e_paddr = '0; e_tag_main = "R7";
            if (kind == 3) e_code = 4'd1;
            else e_code = xq ? 4'd3 : 4'd2;
            return;
        end
        e_paddr = {ppn, va[OFS_W-1:0]};
        rd = (priv <= rb) ? 1 : 0;
        wr = (priv <= wb) ? 2 : 0;
        ex = (priv >= wb && priv <= rb) ? 4 : 0;
        if (typ == 0)      r = rd;
        else if (typ == 1) r = rd + wr;
        else if (typ == 2) r = rd + ex;
        else if (typ == 3) r = rd + wr + ex;
        else               r = ex;
        e_code = 4'd0;
        e_tag_main = "R2";
        if (kind == 0) begin
            e_rights = r[2:0];
            return;
        end
        want_bit = (kind == 1) ? 1 : (kind == 2) ? 2 : 4;
        if ((r / want_bit) % 2 == 0) begin
            e_rights = r[2:0];
            e_tag_main = "R5";
            if (kind == 3)      e_code = 4'd4;
            else if (r % 2 == 1) e_code = 4'd5;
            else                e_code = 4'd6;
            return;
        end
        if (!d || b || t) e_tag_main = "R6";
        if (!d) begin
            if (kind == 2) e_code = 4'd7;
            r = r % 2 + ((r / 4) % 2) * 4;
        end
        if (b) begin
            if (kind == 2) e_code = 4'd8;
            r = r % 2 + ((r / 4) % 2) * 4;
        end
        if (t) begin
            if (kind != 3) e_code = 4'd9;
            r = ((r / 4) % 2) * 4;
        end
        e_rights = r[2:0];
    endtask

    task automatic check_pending();
        if (!pend) return;
        chk("R9 rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R10 fault_valid", 64'(rsp_fault_valid), 64'(e_code != 4'd0));
        if (e_tag_main == "R2") chk("R8 paddr", 64'(rsp_paddr), 64'(e_paddr));
        else chk({e_tag_main, " paddr"}, 64'(rsp_paddr), 64'(e_paddr));
        if (e_probe && e_tag_main == "R2") begin
            if (e_type == 3'd3) chk("R1 rights", 64'(rsp_rights), 64'(e_rights));
            else                chk("R2 rights", 64'(rsp_rights), 64'(e_rights));
            chk("R4 fault", 64'(rsp_fault), 64'(e_code));
        end else begin
            chk({e_tag_main, " rights+fault"}, {57'd0, rsp_rights, rsp_fault},
                {57'd0, e_rights, e_code});
        end
        pend = 1'b0;
    endtask

    task automatic drive(input logic phys, input logic hit, input logic xq,
                         input int kind, input int priv, input int typ,
                         input int rb, input int wb, input logic d,
                         input logic b, input logic t,
                         input logic [ADDR_W-1:0] va, input logic [PPN_W-1:0] ppn);
        req_valid = 1'b1; req_phys = phys; req_hit = hit; req_xlate_query = xq;
        req_kind = kind[1:0]; req_priv = priv[1:0]; ent_type = typ[2:0];
        ent_pl1 = rb[1:0]; ent_pl2 = wb[1:0]; ent_dirty = d; ent_break = b;
        ent_trap = t; req_vaddr = va; ent_ppn = ppn;
        model(phys, hit, xq, kind, priv, typ, rb, wb, d, b, t, va, ppn);
        pend = 1'b1;
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : stim
        int idx;
        idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R9 R10
        chk("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 reset fault", {62'd0, rsp_fault_valid, |rsp_fault}, 64'd0);
        chk("R9 reset rights", 64'(rsp_rights), 64'd0);
        rst_n = 1'b1;

        // exhaustive hit sweep: R1 R2 R4 R5 R6 R8
        for (int k = 0; k < 4; k++)
            for (int ty = 0; ty < 8; ty++)
                for (int rb = 0; rb < 4; rb++)
                    for (int wb = 0; wb < 4; wb++)
                        for (int p = 0; p < 4; p++)
                            for (int f = 0; f < 8; f++) begin
                                @(negedge clk);
                                check_pending();
                                drive(1'b0, 1'b1, 1'b0, k, p, ty, rb, wb,
                                      f[0], f[1], f[2],
                                      32'(idx) * 32'h9E3779B1 ^ 32'h0000_05A5,
                                      PPN_W'(idx * 7 + 3));
                                idx++;
                            end

        // physical mode ignores entry and hit: R3
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            check_pending();
            drive(1'b1, i[0], i[1], i % 4, (i / 4) % 4, i % 8, (i / 2) % 4,
                  (i / 3) % 4, i[2], i[3], i[4],
                  32'(i) * 32'h7F4A7C15 + 32'h1234, PPN_W'(i));
        end

        // misses: R7
        for (int k = 0; k < 4; k++)
            for (int q = 0; q < 2; q++) begin
                @(negedge clk);
                check_pending();
                drive(1'b0, 1'b0, q[0], k, 0, 3, 3, 0, 1'b1, 1'b0, 1'b0,
                      32'hCAFE_0000 + 32'(k), PPN_W'(5));
            end

        // drain: R9
        @(negedge clk);
        check_pending();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 drop rsp_valid", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk("R9 idle rsp_valid", 64'(rsp_valid), 64'd0);
        finish_run();
    end

endmodule